// File: doc/BRIEF.md
# Three-Phase Time-Step Sequencer

The sequencer paces a small synchronous datapath. It divides the master clock into a repeating cycle of time steps. One one-hot line marks the current step, and one pulse line per step marks its middle third. Each time step lasts three master-clock sub-steps. In the first sub-step only the step line is high. In the second, the step line and its pulse line are both high. In the third, the step line is high again and the pulse line is low. After the last step of the cycle the sequence returns to the first step. Downstream registers use the rising edge of a pulse line as their load strobe.

The sequencer does not run on its own. After reset it waits at the first sub-step of step 1. A one-cycle request pulse starts a run in one of four modes: a single sub-step, one whole time step, one whole cycle, or free running. Each mode halts at its own boundary. Requests that arrive while a run is in progress are dropped. Only reset stops free running. The number of steps per cycle is a parameter.

Top module: `phase_sequencer`

## Requirements
- R1: Synchronous active-high reset puts the block at the first sub-step of step 1, with `t_out` = 1 and `p_out` = 0, and stopped. While stopped and with no request, the outputs do not change.
- R2: Each time step i (bit i-1 of the outputs) has three sub-steps in this order: `t_out` bit alone, then the `t_out` bit together with the same `p_out` bit, then the `t_out` bit alone. After the third sub-step of the last step comes the first sub-step of step 1.
- R3: Exactly one bit of `t_out` is high at all times. At most one bit of `p_out` is high, and a high `p_out` bit is always the same bit as the high `t_out` bit.
- R4: A `req_step` pulse from the stopped state advances the position by exactly one sub-step, and the block then stops.
- R5: A `req_time` pulse from the stopped state advances the position until the first sub-step of the next time step is reached, and the block then stops there.
- R6: A `req_cycle` pulse from the stopped state advances the position until the first sub-step of step 1 is reached, and the block then stops there. Starting from that position, this takes 3 × `N_STEPS` sub-steps.
- R7: A `req_auto` pulse from the stopped state makes the position advance by one sub-step on every clock and wrap without end, until reset.
- R8: A request of any kind that arrives while a run is in progress is ignored and does not change where the run halts.
- R9: When several requests arrive together in the stopped state, the mode chosen is `req_step` first, then `req_time`, then `req_cycle`, then `req_auto`.
- R10: The first advance takes place at the same clock edge that samples the request. The outputs show the new sub-step right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| req_step | input | 1 | Request pulse: advance one sub-step |
| req_time | input | 1 | Request pulse: advance one time step |
| req_cycle | input | 1 | Request pulse: advance one full cycle |
| req_auto | input | 1 | Request pulse: free running |
| t_out | output | N_STEPS | One-hot time-step lines, bit 0 is step 1 |
| p_out | output | N_STEPS | Mid-step pulse lines, bit 0 is step 1 |

## Verification
The assertions assume that request pulses are synchronous to `clk` and stable around its rising edge. They also assume that reset is the only way to leave free running. Requests may therefore arrive at any time, in any combination, and even during a run, because the block is specified to drop them. The stimulus drives every input just after the falling edge. It mixes random request bursts, including simultaneous ones, with occasional resets, so that every free run ends and the other modes keep getting exercised.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    RUN_IDLE  = 3'd0,
    RUN_STEP  = 3'd1,
    RUN_TIME  = 3'd2,
    RUN_CYCLE = 3'd3,
    RUN_AUTO  = 3'd4
  } run_mode_e;

  // Fixed priority among simultaneous requests: step, time, cycle, auto.
  function automatic run_mode_e pick_request(input logic r_step, input logic r_time,
                                             input logic r_cycle, input logic r_auto);
    if (r_step)       return RUN_STEP;
    else if (r_time)  return RUN_TIME;
    else if (r_cycle) return RUN_CYCLE;
    else if (r_auto)  return RUN_AUTO;
    else              return RUN_IDLE;
  endfunction

endpackage

// File: rtl/seq_run_ctrl.sv
module seq_run_ctrl
  import seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      req_step,
  input  logic      req_time,
  input  logic      req_cycle,
  input  logic      req_auto,
  input  logic      end_of_step,
  input  logic      end_of_cycle,
  output logic      advance,
  output run_mode_e mode
);

  run_mode_e eff_mode;
  logic      halt_now;

  // A run in progress masks every new request.
  always_comb begin
    if (mode != RUN_IDLE) eff_mode = mode;
    else                  eff_mode = pick_request(req_step, req_time, req_cycle, req_auto);
  end

  assign advance = (eff_mode != RUN_IDLE);

  // Halt when the sub-step being entered is the boundary of the active mode.
  always_comb begin
    unique case (eff_mode)
      RUN_STEP:  halt_now = 1'b1;
      RUN_TIME:  halt_now = end_of_step;
      RUN_CYCLE: halt_now = end_of_cycle;
      default:   halt_now = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           mode <= RUN_IDLE;
    else if (halt_now) mode <= RUN_IDLE;
    else               mode <= eff_mode;
  end

  AST_STEP_HALTS: assert property (@(posedge clk) disable iff (rst)
    (mode == RUN_IDLE && req_step) |=> (mode == RUN_IDLE)); // R4

  AST_TIME_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (mode == RUN_TIME) |=> (mode == RUN_TIME || mode == RUN_IDLE)); // R8

  AST_CYCLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (mode == RUN_CYCLE) |=> (mode == RUN_CYCLE || mode == RUN_IDLE)); // R8

  AST_AUTO_FOREVER: assert property (@(posedge clk) disable iff (rst)
    (mode == RUN_AUTO) |=> (mode == RUN_AUTO)); // R7

endmodule

// File: rtl/seq_position.sv
module seq_position #(
  parameter int N_STEPS = 4,
  localparam int STEP_W = (N_STEPS > 1) ? $clog2(N_STEPS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  output logic [STEP_W-1:0] step_idx,
  output logic [1:0]        sub_idx,
  output logic [STEP_W-1:0] next_step,
  output logic [1:0]        next_sub,
  output logic              end_of_step,
  output logic              end_of_cycle
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS - 1);
  localparam logic [1:0]        LAST_SUB  = 2'd2;

  logic on_last_sub;

  assign on_last_sub = (sub_idx == LAST_SUB);

  // Flags describe the position that the next advance lands on.
  assign end_of_step  = on_last_sub;
  assign end_of_cycle = on_last_sub && (step_idx == LAST_STEP);

  always_comb begin
    next_sub  = sub_idx;
    next_step = step_idx;
    if (advance) begin
      if (on_last_sub) begin
        next_sub  = 2'd0;
        next_step = (step_idx == LAST_STEP) ? '0 : step_idx + 1'b1;
      end else begin
        next_sub = sub_idx + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_idx <= '0;
      sub_idx  <= 2'd0;
    end else begin
      step_idx <= next_step;
      sub_idx  <= next_sub;
    end
  end

  AST_WRAP_TO_FIRST: assert property (@(posedge clk) disable iff (rst)
    (advance && end_of_cycle) |=> (step_idx == '0 && sub_idx == 2'd0)); // R2

  AST_SUB_RANGE: assert property (@(posedge clk) disable iff (rst)
    sub_idx != 2'd3); // R2

endmodule

// File: rtl/seq_phase_out.sv
module seq_phase_out #(
  parameter int N_STEPS = 4,
  localparam int STEP_W = (N_STEPS > 1) ? $clog2(N_STEPS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STEP_W-1:0]  next_step,
  input  logic [1:0]         next_sub,
  output logic [N_STEPS-1:0] t_out,
  output logic [N_STEPS-1:0] p_out
);

  localparam logic [1:0] PULSE_SUB = 2'd1;

  logic pulse_slot;

  assign pulse_slot = (next_sub == PULSE_SUB);

  for (genvar g = 0; g < N_STEPS; g++) begin : g_line
    logic hit;
    assign hit = (next_step == STEP_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        t_out[g] <= (g == 0);
        p_out[g] <= 1'b0;
      end else begin
        t_out[g] <= hit;
        p_out[g] <= hit && pulse_slot;
      end
    end
  end

  AST_T_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(t_out) == 1); // R3

  AST_P_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(p_out)); // R3

  AST_P_WITH_T: assert property (@(posedge clk) disable iff (rst)
    (p_out != '0) |-> ((p_out & t_out) == p_out)); // R3

endmodule

// File: rtl/phase_sequencer.sv
module phase_sequencer
  import seq_pkg::*;
#(
  parameter int N_STEPS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_step,
  input  logic               req_time,
  input  logic               req_cycle,
  input  logic               req_auto,
  output logic [N_STEPS-1:0] t_out,
  output logic [N_STEPS-1:0] p_out
);

  localparam int STEP_W = (N_STEPS > 1) ? $clog2(N_STEPS) : 1;

  logic              advance;
  logic              end_of_step;
  logic              end_of_cycle;
  logic [STEP_W-1:0] step_idx;
  logic [STEP_W-1:0] next_step;
  logic [1:0]        sub_idx;
  logic [1:0]        next_sub;
  run_mode_e         mode;

  seq_run_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .req_step     (req_step),
    .req_time     (req_time),
    .req_cycle    (req_cycle),
    .req_auto     (req_auto),
    .end_of_step  (end_of_step),
    .end_of_cycle (end_of_cycle),
    .advance      (advance),
    .mode         (mode)
  );

  seq_position #(.N_STEPS(N_STEPS)) u_pos (
    .clk          (clk),
    .rst          (rst),
    .advance      (advance),
    .step_idx     (step_idx),
    .sub_idx      (sub_idx),
    .next_step    (next_step),
    .next_sub     (next_sub),
    .end_of_step  (end_of_step),
    .end_of_cycle (end_of_cycle)
  );

  seq_phase_out #(.N_STEPS(N_STEPS)) u_out (
    .clk       (clk),
    .rst       (rst),
    .next_step (next_step),
    .next_sub  (next_sub),
    .t_out     (t_out),
    .p_out     (p_out)
  );

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode == RUN_IDLE && !(req_step || req_time || req_cycle || req_auto))
      |=> ($stable(t_out) && $stable(p_out))); // R1

  AST_PULSE_MIDDLE: assert property (@(posedge clk) disable iff (rst)
    ((p_out != '0) == (sub_idx == 2'd1))); // R2

  AST_REQ_MOVES: assert property (@(posedge clk) disable iff (rst)
    (mode == RUN_IDLE && (req_step || req_time || req_cycle || req_auto))
      |=> !($stable(t_out) && $stable(p_out))); // R10

endmodule

// File: tb/sim_phase_sequencer.sv
module sim_phase_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int LEN = 3 * N;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         rq_s = 1'b0, rq_t = 1'b0, rq_c = 1'b0, rq_a = 1'b0;
  logic [N-1:0] t_out, p_out;

  int n_checks = 0;
  int n_fail = 0;
  int m_pos = 0;   // model position 0..LEN-1
  int m_mode = 0;  // 0 stopped, 1 step, 2 time, 3 cycle, 4 auto
  bit done = 0;

  phase_sequencer #(.N_STEPS(N)) u0 (
    .clk(clk), .rst(rst), .req_step(rq_s), .req_time(rq_t),
    .req_cycle(rq_c), .req_auto(rq_a), .t_out(t_out), .p_out(p_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [N-1:0] exp_t(input int pos);
    return N'(1) << (pos / 3);
  endfunction

  function automatic logic [N-1:0] exp_p(input int pos);
    return (pos % 3 == 1) ? exp_t(pos) : '0;
  endfunction

  // Model of one clock edge, written from the requirements.
  task automatic model_edge();
    int eff;
    bit stop;
    if (rst) begin
      m_pos = 0; m_mode = 0;
    end else begin
      eff = m_mode;
      if (eff == 0) eff = rq_s ? 1 : rq_t ? 2 : rq_c ? 3 : rq_a ? 4 : 0;
      if (eff != 0) begin
        m_pos = (m_pos + 1) % LEN;
        stop = (eff == 1) || (eff == 2 && m_pos % 3 == 0) || (eff == 3 && m_pos == 0);
        m_mode = stop ? 0 : eff;
      end
    end
  endtask

  task automatic check(input string tag);
    n_checks++;
    if (t_out !== exp_t(m_pos) || p_out !== exp_p(m_pos)) begin
      n_fail++;
      $display("FAIL %s: t=%b p=%b expected t=%b p=%b", tag, t_out, p_out,
               exp_t(m_pos), exp_p(m_pos));
    end
    n_checks++;
    if ($countones(t_out) != 1 || $countones(p_out) > 1 || (p_out & ~t_out) != '0) begin
      n_fail++;
      $display("FAIL R3: t=%b p=%b expected one-hot t, p within t", t_out, p_out);
    end
  endtask

  // Drive inputs after a falling edge, step one clock, check after next falling edge.
  task automatic cyc(input bit s, input bit t, input bit c, input bit a, input bit r,
                     input string tag);
    rq_s = s; rq_t = t; rq_c = c; rq_a = a; rst = r;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    rq_s = 0; rq_t = 0; rq_c = 0; rq_a = 0; rst = 0;
    check(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    cyc(0, 0, 0, 0, 1, "R1");
    cyc(0, 0, 0, 0, 1, "R1");
    idle(3, "R1");

    // R4 and R2: single sub-steps walk through the pattern
    for (int i = 0; i < 7; i++) begin
      cyc(1, 0, 0, 0, 0, "R4");
      idle(1, "R2");
    end
    // R5 with a cycle request inside the run (R8)
    cyc(0, 1, 0, 0, 0, "R10");
    cyc(0, 0, 1, 0, 0, "R8");
    idle(4, "R5");
    // R6 from the start of step 1
    cyc(0, 0, 0, 0, 1, "R1");
    cyc(0, 0, 1, 0, 0, "R10");
    for (int i = 0; i < LEN + 3; i++) cyc(i == 4, i == 5, 0, i == 6, 0, "R6");
    // R9: every request together picks single step
    cyc(1, 1, 1, 1, 0, "R9");
    idle(3, "R9");
    cyc(0, 1, 1, 1, 0, "R9");
    idle(4, "R9");
    // R7 free running over two cycles
    cyc(0, 0, 0, 1, 0, "R7");
    for (int i = 0; i < 2 * LEN; i++) cyc(i == 3, i == 5, 0, 0, 0, "R7");
    cyc(0, 0, 0, 0, 1, "R1");

    // Constrained random mix
    void'($urandom(32'd4242));
    for (int i = 0; i < 600; i++) begin
      cyc(($urandom % 8) == 0, ($urandom % 10) == 0, ($urandom % 14) == 0,
          ($urandom % 30) == 0, ($urandom % 60) == 0, "R2");
    end
    finish_run();
  end

endmodule